// File: doc/BRIEF.md
# Dual-Channel UART Bit-Rate Tick Generator

This block derives two independent bit-rate strobes, one for a transmitter and one for a receiver, from the system clock. A 3-bit source select picks the count source. It is either a power-of-two division of the system clock, from /2 up to /128, or the rising edges of an external clock pin. A 4-bit modulus sets how many source ticks make up one half of an output period.

Each direction has its own 5-bit counter and its own trailing divide-by-two stage, and each is gated by its own enable. The outputs are one-cycle enable pulses in the system clock domain. They are not derived clocks.

The source select and the modulus both live in an 8-bit control register written through a plain write strobe. The block has no streaming data path, so every pin is a plain control or status pin. The external pin is assumed to be already synchronised to the system clock.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset the control register holds zero, and neither `tx_tick` nor `rx_tick` pulses while both enables are low.
- R2: With source select n in the range 0..6, the source tick arrives once every 2^(n+1) system clocks. An enabled channel then pulses every 2·(16+M)·2^(n+1) clocks, where M is the modulus.
- R3: The modulus M (0..15) makes each channel counter wrap after 16+M source ticks. Every second wrap produces one output pulse.
- R4: Source select 7 counts rising edges of `ext_clk`, so an enabled channel pulses once every 2·(16+M) rising edges.
- R5: Every output pulse lasts exactly one system clock.
- R6: While `tx_en` is low, `tx_tick` stays low and the transmit counter and its divide-by-two flop are held cleared. After `tx_en` rises, the first pulse comes between (2(16+M)−1)·P+1 and 2(16+M)·P+2 clocks later, where P is the source tick period.
- R7: The receive channel runs independently under `rx_en`. When both channels are enabled on the same clock with the same settings, their pulses coincide. Dropping one enable does not disturb the other channel.
- R8: A write stores `cfg_wdata[6:4]` as the source select and `cfg_wdata[3:0]` as the modulus, effective from the next clock. Bit 7 is ignored and has no effect on the output rates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External count source, already synchronised |
| tx_en | input | 1 | Transmit channel enable |
| rx_en | input | 1 | Receive channel enable |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data: [6:4] source select, [3:0] modulus, [7] ignored |
| tx_tick | output | 1 | One-cycle transmit bit-rate strobe |
| rx_tick | output | 1 | One-cycle receive bit-rate strobe |

## Verification
The two channels share one source tick, so a transmit pulse and a receive pulse can fall in the same cycle. This is provoked by raising both enables on one clock under every swept setting. The bench then requires `rx_tick` to be high in exactly the sample where `tx_tick` is first seen. A channel being disabled while the other keeps counting can also land in that cycle. That case is judged by holding `tx_tick` silent while the receive pulses keep arriving.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int SEL_W  = 3;
  localparam int MOD_W  = 4;
  localparam int CNT_W  = MOD_W + 1;
  localparam int CTRL_W = 8;
  localparam int N_CH   = 2;

  typedef struct packed {
    logic [SEL_W-1:0] src_sel;
    logic [MOD_W-1:0] modulus;
  } baud_cfg_t;
endpackage

// File: rtl/bg_prescaler.sv
module bg_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic [SEL_W-1:0] src_sel,
  output logic             src_tick
);
  localparam int DIV_W   = (1 << SEL_W) - 1;
  localparam int EXT_SEL = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             ext_q;
  logic             ext_rise;
  logic             int_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ext_q <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      ext_q <= ext_clk;
    end
  end

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i <= int'(src_sel));
  end

  assign int_tick = ((div_q & mask) == mask);
  assign ext_rise = ext_clk & ~ext_q;
  assign src_tick = (int'(src_sel) == EXT_SEL) ? ext_rise : int_tick;
endmodule

// File: rtl/bg_channel.sv
module bg_channel #(
  parameter int MOD_W = 4,
  parameter int CNT_W = MOD_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             src_tick,
  input  logic [MOD_W-1:0] modulus,
  output logic             tick
);
  localparam int BASE = 1 << MOD_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             half_q;

  assign last = CNT_W'(BASE - 1) + CNT_W'(modulus);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      tick   <= 1'b0;
    end else if (!en) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      tick   <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (src_tick) begin
        if (cnt_q >= last) begin
          cnt_q  <= '0;
          half_q <= ~half_q;
          tick   <= half_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import baud_gen_pkg::*;
#(
  parameter int CW = CTRL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_clk,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_wdata,
  output logic          tx_tick,
  output logic          rx_tick
);
  localparam int CFG_BITS = SEL_W + MOD_W;

  baud_cfg_t        cfg_q;
  logic             src_tick;
  logic [N_CH-1:0]  ch_en;
  logic [N_CH-1:0]  ch_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= baud_cfg_t'(cfg_wdata[CFG_BITS-1:0]);
  end

  bg_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_clk  (ext_clk),
    .src_sel  (cfg_q.src_sel),
    .src_tick (src_tick)
  );

  assign ch_en = {rx_en, tx_en};

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    bg_channel #(.MOD_W(MOD_W), .CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ch_en[g]),
      .src_tick (src_tick),
      .modulus  (cfg_q.modulus),
      .tick     (ch_tick[g])
    );
  end

  assign tx_tick = ch_tick[0];
  assign rx_tick = ch_tick[1];
endmodule

// File: rtl/bg_checker.sv
module bg_checker #(
  parameter int MIN_GAP = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       rx_en,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic [6:0] cfg_q,
  input logic       tx_tick,
  input logic       rx_tick
);
  logic [15:0] tx_gap, rx_gap;
  logic        tx_seen, rx_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_gap <= '0; rx_gap <= '0; tx_seen <= 1'b0; rx_seen <= 1'b0;
    end else begin
      tx_gap <= tx_tick ? '0 : ((&tx_gap) ? tx_gap : tx_gap + 1'b1);
      rx_gap <= rx_tick ? '0 : ((&rx_gap) ? rx_gap : rx_gap + 1'b1);
      if (cfg_we)       tx_seen <= 1'b0;
      else if (tx_tick) tx_seen <= 1'b1;
      if (cfg_we)       rx_seen <= 1'b0;
      else if (rx_tick) rx_seen <= 1'b1;
    end
  end

  p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q == $past(cfg_wdata[6:0]));
  p_tx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |=> !tx_tick);
  p_rx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick |=> !rx_tick);
  p_tx_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_tick);
  p_rx_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_tick);
  p_tx_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick && tx_seen) |-> (tx_gap >= 16'(MIN_GAP - 1)));
  p_rx_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tick && rx_seen) |-> (rx_gap >= 16'(MIN_GAP - 1)));
endmodule

bind uart_baud_gen bg_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_en     (tx_en),
  .rx_en     (rx_en),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_q     (cfg_q),
  .tx_tick   (tx_tick),
  .rx_tick   (rx_tick)
);

// File: tb/tb_uart_baud_gen.sv
`timescale 1ns/1ps
module tb_uart_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       tx_en = 1'b0;
  logic       rx_en = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       tx_tick, rx_tick;
  int         n_chk = 0;
  int         n_fail = 0;
  int         ext_div = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  // external source: toggles every 3 clocks -> one rising edge per 6 clocks
  always @(negedge clk) begin
    if (ext_div == 2) begin ext_div <= 0; ext_clk <= ~ext_clk; end
    else ext_div <= ext_div + 1;
  end

  uart_baud_gen dut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .tx_en(tx_en), .rx_en(rx_en),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .tx_tick(tx_tick), .rx_tick(rx_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr_cfg(input int sel, input int md, input bit b7);
    @(negedge clk);
    cfg_wdata = {b7, 3'(sel), 4'(md)};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // counts negedges until the chosen tick is seen high
  task automatic meas(input bit use_rx, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(use_rx ? rx_tick : tx_tick) && n < 40000);
  endtask

  task automatic run_cfg(input int sel, input int md, input bit b7);
    int p, m, per, n, n2;
    p   = (sel == 7) ? 6 : (2 << sel);
    m   = 16 + md;
    per = 2 * m * p;
    tx_en = 1'b0; rx_en = 1'b0;
    wr_cfg(sel, md, b7);
    @(negedge clk);
    tx_en = 1'b1; rx_en = 1'b1;
    meas(1'b0, n);
    chk(n >= (2*m-1)*p + 1 && n <= per + 2, "R6 first tx pulse window", n, per);
    chk(rx_tick == 1'b1, "R7 rx pulse coincides with tx", rx_tick, 1);
    @(negedge clk);
    chk(tx_tick == 1'b0 && rx_tick == 1'b0, "R5 one-cycle pulse", tx_tick, 0);
    meas(1'b0, n2);
    n2 = n2 + 1;
    if (sel == 7)
      chk(n2 == per, "R4 external-source period", n2, per);
    else if (b7)
      chk(n2 == per, "R8 bit7 ignored period", n2, per);
    else
      chk(n2 == per, "R2/R3 prescaled period", n2, per);
    meas(1'b1, n);
    chk(n == per, "R7 rx period", n, per);
    tx_en = 1'b0; rx_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      summary();
    end
  end

  initial begin
    int cnt, rxc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, no pulses while disabled
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_tick || rx_tick) cnt++;
    end
    chk(cnt == 0, "R1 no pulses after reset", cnt, 0);
    // R1: default config (sel 0, mod 0) gives period 64
    tx_en = 1'b1;
    begin
      int a, b;
      meas(1'b0, a);
      meas(1'b0, b);
      chk(b == 64, "R1 reset config period", b, 64);
    end
    tx_en = 1'b0;
    // R3: modulus sweep at select 0
    for (int md = 0; md < 16; md++) run_cfg(0, md, 1'b0);
    // R2: select sweep at both modulus extremes
    for (int s = 0; s < 7; s++) begin
      run_cfg(s, 0, 1'b0);
      run_cfg(s, 15, 1'b0);
    end
    // R4: external source
    run_cfg(7, 0, 1'b0);
    run_cfg(7, 9, 1'b0);
    // R8: bit 7 set has no effect
    run_cfg(1, 3, 1'b1);
    run_cfg(0, 7, 1'b1);
    // R6/R7: drop tx while rx keeps running
    wr_cfg(0, 0, 1'b0);
    @(negedge clk);
    tx_en = 1'b1; rx_en = 1'b1;
    begin
      int a;
      meas(1'b1, a);
    end
    tx_en = 1'b0;
    cnt = 0; rxc = 0;
    for (int i = 0; i < 320; i++) begin
      @(negedge clk);
      if (tx_tick) cnt++;
      if (rx_tick) rxc++;
    end
    chk(cnt == 0, "R6 tx silent while disabled", cnt, 0);
    chk(rxc == 5, "R7 rx unaffected by tx disable", rxc, 5);
    tx_en = 1'b1;
    begin
      int a;
      meas(1'b0, a);
      chk(a >= 63 && a <= 66, "R6 restart phase after enable", a, 64);
    end
    tx_en = 1'b0; rx_en = 1'b0;
    done = 1'b1;
    summary();
  end
endmodule